// File: doc/BRIEF.md
# Nibble-Serial CRC-4 Word Checker

This block takes one word made of a data field and a 4-bit check field and decides whether the check field is the correct CRC-4 of the data. It works through the data four bits at a time, one nibble per clock. Each step looks the old CRC, XORed with the current nibble, up in a fixed 16-entry table. The default data field is 28 bits wide, which makes a 32-bit word. A word enters through a valid/ready handshake. Some cycles later a one-cycle `done` pulse marks the moment the computed CRC and the match verdict are on the outputs, and they stay there until the next word finishes.

For chained or streaming use, a caller can raise `in_chain` when it hands over a word. The CRC register then starts from `in_seed` instead of zero. The value on `crc_out` can be carried into the next word as its seed. Fetching the word and any retry after a mismatch belong to the caller.

Top module: `nibble_crc4_check`

## Requirements
- R1: Each step replaces the CRC with T[crc XOR nibble], where T indexed 0..15 is 0,7,E,9,B,C,5,2,1,6,F,8,A,D,4,3 (hex).
- R2: The data field is zero-extended to a whole number of nibbles plus one extra leading zero nibble. For 28 data bits that is 8 steps. Nibbles are consumed from the most significant position down to nibble 0.
- R3: In an accepted word, bits [DATA_W+3:4] are the data field and bits [3:0] are the expected CRC. With the default that is data in [31:4] and check in [3:0].
- R4: The CRC register starts at 0 when `in_chain` is low at acceptance and at `in_seed` when `in_chain` is high.
- R5: At `done`, `crc_match` is 1 exactly when `crc_out` equals the check field of the word just processed.
- R6: `in_ready` is the inverse of `busy`. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_valid` while busy has no effect on any output.
- R7: `busy` rises on the acceptance edge. `done` is high for exactly one cycle, starting at the 8th rising edge after acceptance for the default width, and `busy` falls on that same edge.
- R8: `crc_out` and `crc_match` change only on the edge that raises `done`, and they hold their values otherwise.
- R9: A synchronous active-high reset clears `busy`, `done`, `crc_out` and `crc_match`, including in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block idle, word will be taken |
| in_word | input | DATA_W+4 | Data field above a 4-bit check field |
| in_chain | input | 1 | Start from `in_seed` instead of zero |
| in_seed | input | 4 | Starting CRC for chained use |
| busy | output | 1 | Word in progress |
| done | output | 1 | One-cycle completion pulse |
| crc_out | output | 4 | CRC of the last completed word |
| crc_match | output | 1 | Last completed word's check field was correct |

## Verification
The hardest situations to reach from the ports are a word offered while another is still being processed, and a reset that lands partway through a word. In the first case the block must ignore the offer, and the proof is that no extra `done` appears and the results belong to the earlier word. The stimulus holds `in_valid` high with different words across the busy window, runs back-to-back words with no idle gap, and asserts reset in the middle of a word. It also covers seeded chaining with a nonzero starting CRC. That case is the only one where the leading zero nibble changes the result, so it checks the step count as well as the table.

// File: rtl/ncrc_pkg.sv
package ncrc_pkg;

    localparam int CHK_W = 4;
    localparam logic [4:0] NCRC_POLY = 5'h17;

    typedef logic [CHK_W-1:0] nib_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ncrc_state_e;

    typedef struct packed {
        nib_t crc;
        logic match;
    } ncrc_res_t;

    // steps per word: nibble-rounded field plus one leading zero nibble
    function automatic int ncrc_steps(input int data_w);
        return ((data_w + 3) / 4) + 1;
    endfunction

    // table entry = (v * x^4) mod poly, computed rather than listed
    function automatic nib_t ncrc_lut(input nib_t v);
        logic [7:0] acc;
        acc = {v, 4'b0000};
        for (int i = 7; i >= 4; i--) begin
            if (acc[i]) begin
                acc = acc ^ (8'(NCRC_POLY) << (i - 4));
            end
        end
        return acc[3:0];
    endfunction

endpackage

// File: rtl/ncrc_step.sv
module ncrc_step
    import ncrc_pkg::*;
#(
    parameter bit USE_LUT = 1'b1
) (
    input  nib_t crc_in,
    input  nib_t nib_in,
    output nib_t crc_nxt
);

    nib_t idx;
    assign idx = crc_in ^ nib_in;

    generate
        if (USE_LUT) begin : g_lut
            assign crc_nxt = ncrc_lut(idx);
        end else begin : g_shift
            // four feedback shifts, equivalent to one table lookup
            nib_t stage [0:4];
            assign stage[0] = idx;
            for (genvar k = 0; k < 4; k++) begin : g_bit
                assign stage[k+1] = {stage[k][2:0], 1'b0}
                                  ^ (stage[k][3] ? 4'h7 : 4'h0);
            end
            assign crc_nxt = stage[4];
        end
    endgenerate

endmodule

// File: rtl/ncrc_seq.sv
module ncrc_seq
    import ncrc_pkg::*;
#(
    parameter int NSTEPS = 8,
    localparam int CNT_W = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    output logic busy,
    output logic done,
    output logic load,
    output logic step,
    output logic last
);

    ncrc_state_e       st_q;
    logic [CNT_W-1:0]  cnt_q;

    assign in_ready = (st_q == ST_IDLE);
    assign busy     = (st_q == ST_RUN);
    assign load     = in_ready && in_valid;
    assign step     = busy;
    assign last     = busy && (cnt_q == CNT_W'(NSTEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        st_q  <= ST_RUN;
                        cnt_q <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ncrc_path.sv
module ncrc_path
    import ncrc_pkg::*;
#(
    parameter int DATA_W  = 28,
    parameter int NSTEPS  = 8,
    parameter bit USE_LUT = 1'b1,
    localparam int PAD_W  = NSTEPS * 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] data_in,
    input  logic              chain,
    input  nib_t              seed,
    output nib_t              crc_nxt
);

    logic [PAD_W-1:0] sh_q;
    nib_t             crc_q;

    ncrc_step #(.USE_LUT(USE_LUT)) u_step (
        .crc_in (crc_q),
        .nib_in (sh_q[PAD_W-1 -: 4]),
        .crc_nxt(crc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            crc_q <= '0;
        end else if (load) begin
            sh_q  <= {{(PAD_W - DATA_W){1'b0}}, data_in};
            crc_q <= chain ? seed : '0;
        end else if (step) begin
            sh_q  <= {sh_q[PAD_W-5:0], 4'h0};
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/ncrc_result.sv
module ncrc_result
    import ncrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  nib_t      chk_in,
    input  logic      last,
    input  nib_t      crc_fin,
    output ncrc_res_t res
);

    nib_t chk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q <= '0;
            res   <= '0;
        end else begin
            if (load) begin
                chk_q <= chk_in;
            end
            if (last) begin
                res.crc   <= crc_fin;
                res.match <= (crc_fin == chk_q);
            end
        end
    end

endmodule

// File: rtl/nibble_crc4_check.sv
module nibble_crc4_check
    import ncrc_pkg::*;
#(
    parameter int DATA_W  = 28,
    parameter bit USE_LUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W+3:0]   in_word,
    input  logic                in_chain,
    input  logic [3:0]          in_seed,
    output logic                busy,
    output logic                done,
    output logic [3:0]          crc_out,
    output logic                crc_match
);

    localparam int NSTEPS = ncrc_steps(DATA_W);
    localparam int WORD_W = DATA_W + CHK_W;

    logic      load, step, last;
    nib_t      crc_nxt;
    ncrc_res_t res;

    ncrc_seq #(.NSTEPS(NSTEPS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .step    (step),
        .last    (last)
    );

    ncrc_path #(.DATA_W(DATA_W), .NSTEPS(NSTEPS), .USE_LUT(USE_LUT)) u_path (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .data_in(in_word[WORD_W-1:CHK_W]),
        .chain  (in_chain),
        .seed   (in_seed),
        .crc_nxt(crc_nxt)
    );

    ncrc_result u_res (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .chk_in (in_word[CHK_W-1:0]),
        .last   (last),
        .crc_fin(crc_nxt),
        .res    (res)
    );

    assign crc_out   = res.crc;
    assign crc_match = res.match;

endmodule

// File: rtl/nibble_crc4_sva.sv
module nibble_crc4_sva
    import ncrc_pkg::*;
#(
    parameter int DATA_W = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W+3:0] in_word,
    input logic              busy,
    input logic              done,
    input logic [3:0]        crc_out,
    input logic              crc_match
);

    localparam int NSTEPS = ncrc_steps(DATA_W);

    logic        past_ok;
    logic [15:0] run_cnt;
    logic [3:0]  chk_cp;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b1;
            run_cnt <= '0;
            chk_cp  <= '0;
        end else begin
            if (in_valid && in_ready) begin
                run_cnt <= '0;
                chk_cp  <= in_word[3:0];
            end else if (busy) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R6
    busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    // R6
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == 16'(NSTEPS) && !busy));

    // R5
    match_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (crc_match == (crc_out == chk_cp)));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !done) |-> ($stable(crc_out) && $stable(crc_match)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        (past_ok && $past(rst)) |-> (!busy && !done && crc_out == 4'h0 && !crc_match));

endmodule

bind nibble_crc4_check nibble_crc4_sva #(.DATA_W(DATA_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_word  (in_word),
    .busy     (busy),
    .done     (done),
    .crc_out  (crc_out),
    .crc_match(crc_match)
);

// File: tb/sim_nibble_crc4_check.sv
`timescale 1ns/100ps
module sim_nibble_crc4_check;

    localparam int DW     = 28;
    localparam int NST    = 8;   // 28 bits -> 7 nibbles + 1 leading zero nibble

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        in_chain = 1'b0;
    logic [3:0]  in_seed = '0;
    logic        busy, done;
    logic [3:0]  crc_out;
    logic        crc_match;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    // model state
    int         cd = 0;
    logic [3:0] exp_crc = 0, pend_crc = 0;
    logic       exp_match = 0, pend_match = 0;
    string      tag = "R1 R3";

    always #2.5 clk = ~clk;

    nibble_crc4_check #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_chain(in_chain), .in_seed(in_seed),
        .busy(busy), .done(done), .crc_out(crc_out), .crc_match(crc_match)
    );

    function automatic logic [3:0] ref_crc(input logic [3:0] start, input logic [27:0] data);
        int tab [16] = '{0, 7, 14, 9, 11, 12, 5, 2, 1, 6, 15, 8, 10, 13, 4, 3};
        longint d = longint'(data);
        int c = int'(start);
        for (int i = NST - 1; i >= 0; i--) begin
            c = tab[c ^ int'((d >> (4 * i)) & 15)];
        end
        return 4'(c);
    endfunction

    function automatic logic [31:0] good_word(input logic [27:0] data);
        return {data, ref_crc(4'h0, data)};
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic v, input logic [31:0] w, input logic ch, input logic [3:0] sd);
        bit exp_done;
        @(negedge clk);
        exp_done = 0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                exp_done  = 1;
                exp_crc   = pend_crc;
                exp_match = pend_match;
            end
        end
        check("R7 done", done, exp_done);
        check("R6 busy", busy, cd > 0);
        check("R6 in_ready", in_ready, cd == 0);
        if (exp_done) begin
            check({tag, " crc_out"}, crc_out, exp_crc);
            check("R5 crc_match", crc_match, exp_match);
        end else begin
            check("R8 crc_out hold", crc_out, exp_crc);
            check("R8 crc_match hold", crc_match, exp_match);
        end
        in_valid = v;
        in_word  = w;
        in_chain = ch;
        in_seed  = sd;
        if (v && cd == 0) begin
            cd         = NST + 1;
            pend_crc   = ref_crc(ch ? sd : 4'h0, w[31:4]);
            pend_match = (pend_crc == w[3:0]);
        end
    endtask

    task automatic run_word(input logic [31:0] w, input logic ch, input logic [3:0] sd);
        cyc(1'b1, w, ch, sd);
        for (int i = 0; i < NST + 1; i++) cyc(1'b0, 32'h0, 1'b0, 4'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R9 busy", busy, 0);
        check("R9 done", done, 0);
        check("R9 crc_out", crc_out, 0);
        check("R9 crc_match", crc_match, 0);
        check("R9 in_ready", in_ready, 1);
        rst = 1'b0;
        cd = 0;
        exp_crc = 0;
        exp_match = 0;
    endtask

    initial begin
        do_reset();

        // R1 R3: zero word, then a single 1 in the lowest data nibble -> crc 7
        tag = "R1 R3";
        run_word(32'h0000_0000, 1'b0, 4'h0);
        run_word(32'h0000_0017, 1'b0, 4'h0);
        check("R1 literal crc 7", crc_out, 4'h7);
        check("R5 literal match", crc_match, 1);
        run_word(32'h0000_0016, 1'b0, 4'h0);
        check("R5 literal mismatch", crc_match, 0);

        // R2 R3: order-sensitive patterns
        tag = "R2 R3";
        run_word(good_word(28'h1234567), 1'b0, 4'h0);
        run_word(good_word(28'h7654321), 1'b0, 4'h0);
        run_word(good_word(28'hFFFFFFF), 1'b0, 4'h0);
        run_word(good_word(28'h8000000) ^ 32'h1, 1'b0, 4'h0);
        run_word(32'hFFFF_FFFF, 1'b0, 4'h0);

        // R4: seeded start; leading zero nibble matters here (seed 5 over zero data -> C)
        tag = "R4";
        run_word(32'h0000_000C, 1'b1, 4'h5);
        check("R4 seeded literal", crc_out, 4'hC);
        run_word(good_word(28'hABCDEF0), 1'b1, 4'h9);
        run_word(good_word(28'hABCDEF0), 1'b1, 4'h0);

        // R6: offers while busy are ignored; back-to-back words
        tag = "R6 R1";
        cyc(1'b1, good_word(28'h0F0F0F0), 1'b0, 4'h0);
        for (int i = 0; i < 40; i++) cyc(1'b1, 32'h1357_9BDF + 32'(i * 977), i[0], 4'(i));
        for (int i = 0; i < NST + 2; i++) cyc(1'b0, 32'h0, 1'b0, 4'h0);

        // random mix with gaps
        tag = "R1 R2 R4";
        for (int n = 0; n < 60; n++) begin
            logic [31:0] w;
            w = $urandom();
            if (n % 3 == 0) w = good_word(w[31:4]);
            cyc(1'b1, w, w[5], w[11:8]);
            for (int g = 0; g < int'(w[14:12]); g++) cyc(1'b0, $urandom(), 1'b0, 4'h0);
        end
        for (int i = 0; i < NST + 2; i++) cyc(1'b0, 32'h0, 1'b0, 4'h0);

        // R9: reset in the middle of a word
        cyc(1'b1, good_word(28'h2468ACE), 1'b0, 4'h0);
        cyc(1'b0, 32'h0, 1'b0, 4'h0);
        cyc(1'b0, 32'h0, 1'b0, 4'h0);
        cyc(1'b0, 32'h0, 1'b0, 4'h0);
        do_reset();
        for (int i = 0; i < NST + 2; i++) cyc(1'b0, 32'h0, 1'b0, 4'h0);
        tag = "R1 R9";
        run_word(good_word(28'h2468ACE), 1'b0, 4'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule